// File: doc/BRIEF.md
# Four-Channel Frame-Aligned Serializer

The block takes four sample channels that are captured at the same instant and merges them into one serial output stream. Each channel has a 32-word first-word-fall-through buffer. A sequencer empties the buffers in a fixed rotating channel order. Each output word carries the index of the channel it came from, so a downstream consumer can split the stream back into channels. Everything runs on one clock. The output is a valid/ready stream with data, a channel index and a start-of-frame marker.

Reading is done only in whole frames. A frame begins only when all four buffers hold the same non-zero number of words. Once a frame has started, it runs through all four channels before the next frame can begin, so the channel order cannot slip. A write into a full buffer is dropped and raises a sticky per-channel overflow bit. If the buffer fill levels differ at a frame boundary, a sticky misalignment bit is raised. The block then discards words from the fuller buffers until all four fill levels match again.

The output side is expected to run much faster than the sample rate, so the buffers are normally close to empty.

Top module: `quad_frame_serializer`

## Requirements
- R1: Output words are tagged on `out_chan` with channel index 0, 1, 2, 3 in that order. After the channel 3 word is accepted, the next word is from channel 0.
- R2: At a frame boundary (no frame in progress), `out_valid` is high only when all four buffers hold equal, non-zero word counts. Within a frame, `out_valid` stays high until the channel 3 word is accepted.
- R3: `out_data` is the oldest unread word of the buffer named by `out_chan`, visible before it is read (first-word-fall-through).
- R4: A buffer word is removed only when `out_valid` and `out_ready` are both high. At most one word leaves through the output per cycle.
- R5: `out_sof` is high exactly when the presented word is from channel 0.
- R6: Each buffer holds at most DEPTH words (default 32). A write to a full buffer is dropped, and it sets bit i of `ovf_flag` (bit i belongs to channel i, which is written by `in_wr[i]` with data `in_data[16*i+15:16*i]`). The bit stays set until reset.
- R7: When the four counts are not all equal at a frame boundary, `misalign_flag` is set and stays set, and `out_valid` is low. In each such cycle, every buffer whose count exceeds the smallest count drops its oldest word. This repeats until the counts are equal.
- R8: A synchronous active-high `rst` empties all buffers, returns the sequencer to channel 0, and clears `ovf_flag` and `misalign_flag`.
- R9: While `out_valid` is high and `out_ready` is low, `out_chan`, `out_sof` and `out_data` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_wr | input | 4 | Per-channel write strobe |
| in_data | input | 64 | Four packed samples, channel i in bits 16*i+15:16*i |
| out_ready | input | 1 | Downstream ready |
| out_valid | output | 1 | Output word valid |
| out_data | output | 16 | Output sample |
| out_chan | output | 2 | Channel index of the output sample |
| out_sof | output | 1 | Start of frame, high with channel 0 words |
| ovf_flag | output | 4 | Sticky per-channel overflow |
| misalign_flag | output | 1 | Sticky misalignment indication |

## Verification
A wrong fill count or a wrong read pointer appears at the ports within one cycle. It shows either as `out_valid` at the wrong time or as an `out_data` value that does not match the word written earlier for that channel. A sequencer that slips shows as a wrong `out_chan` or `out_sof` on the next accepted word. An unnoticed fill imbalance shows as `misalign_flag` differing from the reference model in the cycle after the boundary. The bench drives aligned writes, single-channel writes and random per-channel writes under a random back-pressure pattern. It compares every output against a queue model on every clock.

// File: rtl/qfs_pkg.sv
package qfs_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W   = $clog2(NUM_CH);
  typedef logic [CH_W-1:0] chan_t;
endpackage

// File: rtl/qfs_fifo.sv
module qfs_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CW-1:0]     count,
  output logic              full
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              wr_ok, rd_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && (count != '0);

  // storage without reset so the array maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  // head word is visible before the read strobe
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= ptr_next(wr_ptr);
      if (rd_ok) rd_ptr <= ptr_next(rd_ptr);
      count <= count + CW'(wr_ok) - CW'(rd_ok);
    end
  end
endmodule

// File: rtl/qfs_seq.sv
module qfs_seq
  import qfs_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     cnt [NUM_CH],
  input  logic              out_ready,
  output logic [NUM_CH-1:0] pop,
  output logic              out_valid,
  output chan_t             phase,
  output logic              sof,
  output logic              misalign
);
  logic          in_frame;
  logic          all_eq;
  logic [CW-1:0] min_cnt;
  logic          fire;
  logic          skew;

  assign in_frame = (phase != '0);
  assign sof      = !in_frame;

  always_comb begin
    all_eq  = 1'b1;
    min_cnt = cnt[0];
    for (int i = 1; i < NUM_CH; i++) begin
      if (cnt[i] != cnt[0]) all_eq = 1'b0;
      if (cnt[i] < min_cnt) min_cnt = cnt[i];
    end
  end

  assign out_valid = in_frame || (all_eq && (cnt[0] != '0));
  assign fire      = out_valid && out_ready;
  assign skew      = !in_frame && !all_eq;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      pop[i] = (fire && (phase == chan_t'(i))) || (skew && (cnt[i] > min_cnt));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      misalign <= 1'b0;
    end else begin
      if (fire) phase <= phase + chan_t'(1);
      if (skew) misalign <= 1'b1;
    end
  end
endmodule

// File: rtl/quad_frame_serializer.sv
module quad_frame_serializer
  import qfs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        in_wr,
  input  logic [NUM_CH*DATA_W-1:0] in_data,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        out_data,
  output logic [CH_W-1:0]          out_chan,
  output logic                     out_sof,
  output logic [NUM_CH-1:0]        ovf_flag,
  output logic                     misalign_flag
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]     cnt  [NUM_CH];
  logic [DATA_W-1:0] head [NUM_CH];
  logic [NUM_CH-1:0] full;
  logic [NUM_CH-1:0] pop;
  chan_t             phase;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    qfs_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (in_wr[g]),
      .wr_data (in_data[g*DATA_W +: DATA_W]),
      .rd_en   (pop[g]),
      .rd_data (head[g]),
      .count   (cnt[g]),
      .full    (full[g])
    );
  end

  qfs_seq #(.DEPTH(DEPTH)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cnt       (cnt),
    .out_ready (out_ready),
    .pop       (pop),
    .out_valid (out_valid),
    .phase     (phase),
    .sof       (out_sof),
    .misalign  (misalign_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) ovf_flag <= '0;
    else     ovf_flag <= ovf_flag | (in_wr & full);
  end

  assign out_chan = phase;
  assign out_data = head[phase];
endmodule

// File: rtl/qfs_chk.sv
module qfs_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              out_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [1:0]        out_chan,
  input logic              out_sof,
  input logic [3:0]        ovf_flag,
  input logic              misalign_flag
);
  // R1
  chan_step_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && (out_chan != 2'd3) |=> out_valid && (out_chan == $past(out_chan) + 2'd1));
  // R1
  chan_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && (out_chan == 2'd3) |=> (out_chan == 2'd0));
  // R5
  sof_match_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sof == (out_chan == 2'd0)));
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> $stable(out_chan) && $stable(out_data) && $stable(out_sof));
  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag != 4'd0) |=> ((ovf_flag & $past(ovf_flag)) == $past(ovf_flag)));
  // R7
  mis_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    misalign_flag |=> misalign_flag);
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ovf_flag == 4'd0) && !misalign_flag && (out_chan == 2'd0));
endmodule

bind quad_frame_serializer qfs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .out_ready     (out_ready),
  .out_valid     (out_valid),
  .out_data      (out_data),
  .out_chan      (out_chan),
  .out_sof       (out_sof),
  .ovf_flag      (ovf_flag),
  .misalign_flag (misalign_flag)
);

// File: tb/quad_frame_serializer_tb.sv
`timescale 1ns/1ps
module quad_frame_serializer_tb;
  localparam int DW    = 16;
  localparam int DEPTH = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [3:0]    in_wr;
  logic [4*DW-1:0] in_data;
  logic          out_ready;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic [1:0]    out_chan;
  logic          out_sof;
  logic [3:0]    ovf_flag;
  logic          misalign_flag;

  always #10 clk = ~clk;

  quad_frame_serializer #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .in_wr(in_wr), .in_data(in_data),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_chan(out_chan), .out_sof(out_sof), .ovf_flag(ovf_flag),
    .misalign_flag(misalign_flag)
  );

  // reference model state
  logic [DW-1:0] mq [4][$];
  int            m_ph;
  bit   [3:0]    m_ovf;
  bit            m_mis;
  int            total = 0;
  int            bad   = 0;
  int            seqn  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit m_eq();
    for (int i = 1; i < 4; i++) if (mq[i].size() != mq[0].size()) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit m_valid();
    return (m_ph != 0) || (m_eq() && mq[0].size() != 0);
  endfunction

  task automatic model_step();
    int  sz [4];
    int  mn;
    bit  ev;
    if (rst) begin
      for (int i = 0; i < 4; i++) mq[i].delete();
      m_ph = 0; m_ovf = '0; m_mis = 1'b0;
      return;
    end
    for (int i = 0; i < 4; i++) sz[i] = mq[i].size();
    ev = m_valid();
    if (ev && out_ready) begin
      void'(mq[m_ph].pop_front());
      m_ph = (m_ph + 1) % 4;
    end else if (m_ph == 0 && !m_eq()) begin
      m_mis = 1'b1;
      mn = sz[0];
      for (int i = 1; i < 4; i++) if (sz[i] < mn) mn = sz[i];
      for (int i = 0; i < 4; i++) if (sz[i] > mn) void'(mq[i].pop_front());
    end
    for (int i = 0; i < 4; i++) begin
      if (in_wr[i]) begin
        if (sz[i] == DEPTH) m_ovf[i] = 1'b1;
        else mq[i].push_back(in_data[i*DW +: DW]);
      end
    end
  endtask

  task automatic compare();
    bit ev;
    ev = m_valid();
    chk(out_valid == ev, "R2 valid", int'(out_valid), int'(ev));
    if (ev) begin
      chk(out_chan == m_ph[1:0], "R1/R9 chan", int'(out_chan), m_ph);
      chk(out_sof == (m_ph == 0), "R5 sof", int'(out_sof), int'(m_ph == 0));
      chk(out_data == mq[m_ph][0], "R3/R4 data", int'(out_data), int'(mq[m_ph][0]));
    end
    chk(ovf_flag == m_ovf, "R6 overflow", int'(ovf_flag), int'(m_ovf));
    chk(misalign_flag == m_mis, "R7 misalign", int'(misalign_flag), int'(m_mis));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic set_data();
    for (int i = 0; i < 4; i++) begin
      in_data[i*DW +: DW] = {i[1:0], seqn[13:0]};
    end
    seqn++;
  endtask

  // mode 0: aligned sparse writes, always ready
  // mode 1: aligned random writes, random ready
  // mode 2: aligned writes every cycle, never ready
  // mode 3: writes on channel 2 only
  // mode 4: random per-channel writes, random ready
  // mode 5: drain
  task automatic run(input int n, input int mode);
    for (int c = 0; c < n; c++) begin
      set_data();
      case (mode)
        0: begin in_wr = (c % 3 == 0) ? 4'hF : 4'h0; out_ready = 1'b1; end
        1: begin in_wr = ($urandom_range(1) != 0) ? 4'hF : 4'h0; out_ready = ($urandom_range(2) != 0); end
        2: begin in_wr = 4'hF; out_ready = 1'b0; end
        3: begin in_wr = 4'b0100; out_ready = 1'b1; end
        4: begin in_wr = 4'($urandom_range(15)); out_ready = ($urandom_range(1) != 0); end
        default: begin in_wr = 4'h0; out_ready = 1'b1; end
      endcase
      tick();
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_wr = '0; out_ready = 1'b0;
    tick(); tick();
    rst = 1'b0;
    // R8: state after reset
    chk(out_valid == 1'b0, "R8 valid after reset", int'(out_valid), 0);
    chk(ovf_flag == 4'h0, "R8 overflow after reset", int'(ovf_flag), 0);
    chk(misalign_flag == 1'b0, "R8 misalign after reset", int'(misalign_flag), 0);
    chk(out_chan == 2'd0, "R8 channel after reset", int'(out_chan), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(7));
    rst = 1'b1; in_wr = '0; in_data = '0; out_ready = 1'b0;
    m_ph = 0; m_ovf = '0; m_mis = 1'b0;
    @(negedge clk);
    do_reset();
    run(60, 0);    // R1 R3 R5 steady frames
    run(300, 1);   // R4 R9 back-pressure
    run(40, 5);
    run(40, 2);    // R6 fill past DEPTH
    run(200, 5);
    do_reset();    // R8 clears sticky flags
    run(5, 3);     // R7 skew one channel
    run(30, 0);
    do_reset();
    run(600, 4);   // R7 R2 random skew
    run(200, 5);
    run(200, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule